// File: doc/BRIEF.md
# Multi-Bank Clock Divider and Gating

This block turns one fast clock into four output banks of two clock outputs each. All logic runs on the fast clock. Each output is a registered signal that toggles at the rate its bank is set to. Banks 1 and 2 always run at the undivided rate, which is one toggle per fast-clock cycle. Banks 3 and 4 each take a select pair. Bank 3's pair picks divide-by-2, divide-by-4 or undivided. Bank 4's pair picks divide-by-2, an inverted undivided copy, or undivided.

The block has three controls besides the selects. A stop input parks every bank except bank 2, so bank 2 can keep serving as a feedback path. An edge-select input sets the output polarity. A three-level test input does two things. It routes a sampled reference clock straight to all outputs as a bypass. In one combination with the stop input, it turns the bank selects into per-bank disables instead.

Stop and disable requests only take effect while the output is already at its parked level, so gating never produces a shortened pulse.

Top module: `clk_bank_gen`

## Requirements
- R1: A three-level input is a 2-bit code: 2'b00 is LOW, 2'b01 is MID, 2'b11 is HIGH, and 2'b10 is read as MID. Each bank's select pair sits at `bank_sel_i[4*b +: 4]`, with bank index b from 0 to 3. The pair reads LL when both codes are LOW and HH when both are HIGH.
- R2: Banks 1 and 2 (index 0 and 1) toggle on every fast-clock edge in normal operation. The two outputs of any bank are always equal.
- R3: Bank 3 divides by 2 when its select pair reads LL, giving a 4-cycle period. It divides by 4 when the pair reads HH, giving an 8-cycle period. Any other code leaves it undivided.
- R4: Bank 4 divides by 2 when its select pair reads LL. When the pair reads HH, it gives the complement of an undivided output. Any other code leaves it undivided.
- R5: Each bank keeps a phase counter that resets to zero, and returns to zero on the edge its mode changes. With `pe_i` HIGH, a non-inverted output is LOW at phase zero. With `pe_i` LOW, every output is complemented.
- R6: With test LOW and `stop_i` HIGH, banks 1, 3 and 4 park LOW while bank 2 keeps running. Bank 4 in inverted mode parks at the level of `pe_i`.
- R7: A bank's enable changes only on an edge where its ungated next value equals its parked level, so no output pulse is ever shortened.
- R8: With test MID and `stop_i` HIGH, every bank whose pair reads LL parks, and the other banks run normally.
- R9: With test HIGH, or with test MID and `stop_i` LOW, all eight outputs show `ref_i` one edge later, complemented when `pe_i` is LOW.
- R10: While `rst_ni` is LOW, all outputs are LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock standing in for the oscillator |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference clock used in bypass |
| test_i | input | 2 | Three-level test control |
| stop_i | input | 1 | Stop request; HIGH parks the outputs |
| pe_i | input | 1 | Edge/polarity select |
| bank_sel_i | input | 16 | Four select pairs of three-level codes |
| clk_o | output | 8 | Bank outputs; bank b drives bits 2b and 2b+1 |

## Verification
The bench builds the block with the default `PHASE_W` of 3. With that value the slowest output has an 8-cycle period, so segments of a few dozen cycles see every divider wrap, every mode restart and every parking event many times over. Random segments use every code for each pin, including 2'b10, and run against a cycle model of the requirements. Directed segments cover reset, stopping in inverted mode, test-mode disable, bypass and an edge count of the divide-by-4 output.

// File: rtl/clk_bank_pkg.sv
package clk_bank_pkg;
  localparam int unsigned NUM_BANKS = 4;

  typedef enum logic [1:0] {
    TRI_LO  = 2'b00,
    TRI_MID = 2'b01,
    TRI_HI  = 2'b11
  } tri_lvl_e;

  typedef enum logic [1:0] {
    M_DIV1 = 2'd0,
    M_DIV2 = 2'd1,
    M_DIVN = 2'd2,
    M_INV  = 2'd3
  } bank_mode_e;

  function automatic tri_lvl_e tri_dec(input logic [1:0] code);
    unique case (code)
      2'b00:   tri_dec = TRI_LO;
      2'b11:   tri_dec = TRI_HI;
      default: tri_dec = TRI_MID;
    endcase
  endfunction
endpackage

// File: rtl/clk_bank_ctrl.sv
module clk_bank_ctrl
  import clk_bank_pkg::*;
(
  input  logic [1:0]                 test_i,
  input  logic                       stop_i,
  input  logic [4*NUM_BANKS-1:0]     bank_sel_i,
  output logic                       bypass_o,
  output bank_mode_e [NUM_BANKS-1:0] mode_o,
  output logic [NUM_BANKS-1:0]       want_en_o
);
  tri_lvl_e test_lvl;
  logic     stop_all, test_dis;

  always_comb begin
    test_lvl = tri_dec(test_i);
    bypass_o = (test_lvl == TRI_HI) || ((test_lvl == TRI_MID) && !stop_i);
    stop_all = (test_lvl == TRI_LO) && stop_i;
    test_dis = (test_lvl == TRI_MID) && stop_i;
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic sel_ll, sel_hh;
    assign sel_ll = (tri_dec(bank_sel_i[4*g +: 2]) == TRI_LO) &&
                    (tri_dec(bank_sel_i[4*g+2 +: 2]) == TRI_LO);
    assign sel_hh = (tri_dec(bank_sel_i[4*g +: 2]) == TRI_HI) &&
                    (tri_dec(bank_sel_i[4*g+2 +: 2]) == TRI_HI);

    // bank index 1 is the feedback bank: never stopped by stop_all
    if (g == 1) begin : g_fb
      assign want_en_o[g] = !(test_dis && sel_ll);
    end else begin : g_std
      assign want_en_o[g] = !(stop_all || (test_dis && sel_ll));
    end

    if (g < 2) begin : g_fixed
      assign mode_o[g] = M_DIV1;
    end else if (g == 2) begin : g_div
      assign mode_o[g] = sel_ll ? M_DIV2 : (sel_hh ? M_DIVN : M_DIV1);
    end else begin : g_inv
      assign mode_o[g] = sel_ll ? M_DIV2 : (sel_hh ? M_INV : M_DIV1);
    end
  end
endmodule

// File: rtl/clk_bank_div.sv
module clk_bank_div
  import clk_bank_pkg::*;
#(
  parameter int unsigned PHASE_W = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  bank_mode_e mode_i,
  input  logic       pe_i,
  input  logic       want_en_i,
  input  logic       bypass_i,
  input  logic       ref_i,
  output logic [1:0] q_o
);
  localparam int unsigned SLOW_BIT = PHASE_W - 1;

  bank_mode_e         mode_q;
  logic [PHASE_W-1:0] cnt_q, cnt_n;
  logic               en_q, en_n, ph, val, park_lvl, out_q, out_n;

  always_comb begin
    cnt_n = (mode_i != mode_q) ? '0 : cnt_q + PHASE_W'(1);
    unique case (mode_i)
      M_DIV2:  ph = cnt_n[1];
      M_DIVN:  ph = cnt_n[SLOW_BIT];
      default: ph = cnt_n[0];
    endcase
    val      = (mode_i == M_INV) ? (ph ^ pe_i) : (ph ^ ~pe_i);
    park_lvl = (mode_i == M_INV) ? pe_i : 1'b0;
    // enable only moves while the output sits at its park level
    en_n     = (val == park_lvl) ? want_en_i : en_q;
    out_n    = bypass_i ? (ref_i ^ ~pe_i) : (en_n ? val : park_lvl);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_DIV1;
      cnt_q  <= '0;
      en_q   <= 1'b1;
      out_q  <= 1'b0;
    end else begin
      mode_q <= mode_i;
      cnt_q  <= cnt_n;
      en_q   <= en_n;
      out_q  <= out_n;
    end
  end

  assign q_o = {2{out_q}};
endmodule

// File: rtl/clk_bank_gen.sv
module clk_bank_gen
  import clk_bank_pkg::*;
#(
  parameter int unsigned PHASE_W = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ref_i,
  input  logic [1:0]  test_i,
  input  logic        stop_i,
  input  logic        pe_i,
  input  logic [15:0] bank_sel_i,
  output logic [7:0]  clk_o
);
  logic                       bypass;
  bank_mode_e [NUM_BANKS-1:0] mode;
  logic [NUM_BANKS-1:0]       want_en;

  clk_bank_ctrl u_ctrl (
    .test_i     (test_i),
    .stop_i     (stop_i),
    .bank_sel_i (bank_sel_i),
    .bypass_o   (bypass),
    .mode_o     (mode),
    .want_en_o  (want_en)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    clk_bank_div #(.PHASE_W(PHASE_W)) u_div (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_i    (mode[g]),
      .pe_i      (pe_i),
      .want_en_i (want_en[g]),
      .bypass_i  (bypass),
      .ref_i     (ref_i),
      .q_o       (clk_o[2*g +: 2])
    );
  end
endmodule

// File: rtl/clk_bank_gen_chk.sv
module clk_bank_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ref_i,
  input logic [1:0]  test_i,
  input logic        stop_i,
  input logic        pe_i,
  input logic [15:0] bank_sel_i,
  input logic [7:0]  clk_o
);
  logic [19:0] cfg, cfg_q;
  logic [4:0]  quiet_q;
  logic        settled, t_lo, t_mid, t_hi, stp, pe_h, b0_ll, b3_hh;

  assign cfg = {test_i, stop_i, pe_i, bank_sel_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      quiet_q <= '0;
    end else begin
      cfg_q   <= cfg;
      quiet_q <= (cfg != cfg_q) ? 5'd0 : ((quiet_q == 5'd31) ? quiet_q : quiet_q + 5'd1);
    end
  end

  always_comb begin
    settled = quiet_q >= 5'd12;
    t_lo    = cfg_q[19:18] == 2'b00;
    t_hi    = cfg_q[19:18] == 2'b11;
    t_mid   = !t_lo && !t_hi;
    stp     = cfg_q[17];
    pe_h    = cfg_q[16];
    b0_ll   = cfg_q[3:0] == 4'b0000;
    b3_hh   = cfg_q[15:12] == 4'b1111;
  end

  AST_BANK1_TOGGLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled && t_lo && !stp |-> clk_o[0] != $past(clk_o[0])); // R2
  AST_STOP_PARKS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled && t_lo && stp |-> (clk_o[1:0] == 2'b00) && (clk_o[5:4] == 2'b00)); // R6
  AST_FEEDBACK_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled && t_lo && stp |-> clk_o[2] != $past(clk_o[2])); // R6
  AST_INV_PARK_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled && t_lo && stp && b3_hh |-> clk_o[7:6] == {2{pe_h}}); // R6
  AST_TEST_DISABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled && t_mid && stp && b0_ll |-> clk_o[1:0] == 2'b00); // R8
  AST_BYPASS_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_i == 2'b11 |=> clk_o == {8{$past(ref_i ^ ~pe_i)}}); // R9
endmodule

bind clk_bank_gen clk_bank_gen_chk u_chk (.*);

// File: tb/clk_bank_gen_bench.sv
module clk_bank_gen_bench;
  logic        clk = 1'b0, rst_ni = 1'b0, ref_i = 1'b0, stop_i = 1'b0, pe_i = 1'b1;
  logic [1:0]  test_i = 2'b00;
  logic [15:0] bank_sel_i = 16'h5555;
  logic [7:0]  clk_o;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  clk_bank_gen u_clk_bank_gen (
    .clk_i(clk), .rst_ni(rst_ni), .ref_i(ref_i), .test_i(test_i), .stop_i(stop_i),
    .pe_i(pe_i), .bank_sel_i(bank_sel_i), .clk_o(clk_o)
  );

  // cycle model: 0 div1, 1 div2, 2 div4, 3 inverted
  int    m_mode[4], m_cnt[4];
  bit    m_en[4], m_out[4];
  string m_tag[4];

  function automatic int lvl(input logic [1:0] c);
    return (c == 2'b00) ? 0 : ((c == 2'b11) ? 2 : 1);
  endfunction
  function automatic bit pair_ll(input int b);
    return lvl(bank_sel_i[4*b +: 2]) == 0 && lvl(bank_sel_i[4*b+2 +: 2]) == 0;
  endfunction
  function automatic bit pair_hh(input int b);
    return lvl(bank_sel_i[4*b +: 2]) == 2 && lvl(bank_sel_i[4*b+2 +: 2]) == 2;
  endfunction
  function automatic int exp_mode(input int b);
    if (b < 2) return 0;
    if (pair_ll(b)) return 1;
    if (pair_hh(b)) return (b == 2) ? 2 : 3;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < 4; b++) begin
        m_mode[b] = 0; m_cnt[b] = 0; m_en[b] = 1; m_out[b] = 0; m_tag[b] = "R10";
      end
    end else begin
      int tl; bit byp;
      tl  = lvl(test_i);
      byp = (tl == 2) || (tl == 1 && !stop_i);
      for (int b = 0; b < 4; b++) begin
        int md, c; bit ph, val, park, want, rst_ph;
        md     = exp_mode(b);
        rst_ph = (md != m_mode[b]);
        c      = rst_ph ? 0 : (m_cnt[b] + 1) % 8;
        m_mode[b] = md; m_cnt[b] = c;
        ph   = (md == 1) ? c[1] : ((md == 2) ? c[2] : c[0]);
        val  = pe_i ? ph : !ph;
        if (md == 3) val = !val;
        park = (md == 3) ? pe_i : 1'b0;
        want = !((tl == 0) && stop_i && b != 1) && !((tl == 1) && stop_i && pair_ll(b));
        if (val == park) m_en[b] = want;
        m_out[b] = byp ? (pe_i ? ref_i : !ref_i) : (m_en[b] ? val : park);
        if (byp) m_tag[b] = "R9";
        else if (m_en[b] != want) m_tag[b] = "R7";
        else if (!want) m_tag[b] = (tl == 1) ? "R8" : "R6";
        else if (rst_ph || !pe_i) m_tag[b] = "R5";
        else if (tl == 0 && stop_i) m_tag[b] = "R6";
        else m_tag[b] = (b < 2) ? "R2" : ((b == 2) ? "R3" : "R4");
      end
    end
  end

  task automatic compare();
    for (int b = 0; b < 4; b++) begin
      checks++;
      if (clk_o[2*b] !== m_out[b] || clk_o[2*b+1] !== m_out[b]) begin
        errors++;
        $display("FAIL %s bank%0d actual %b expected %b%b", m_tag[b], b + 1,
                 clk_o[2*b +: 2], m_out[b], m_out[b]);
      end
    end
  endtask

  task automatic run(input int n, input bit rnd_ref);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      ref_i = rnd_ref ? 1'($urandom) : ~ref_i;
    end
  endtask

  task automatic check_eq(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] rnd_code();
    return 2'($urandom);
  endfunction

  initial begin
    int unsigned seed;
    int rises;
    seed = $urandom(32'd2024);
    #12;
    check_eq("R10", clk_o, 8'h00);
    @(negedge clk); rst_ni = 1'b1;
    run(20, 0);
    bank_sel_i = 16'hF055;              // bank3 LL, bank4 HH
    run(24, 0);
    stop_i = 1'b1; run(24, 0);          // R6 with pe HIGH
    pe_i = 1'b0; run(24, 0);            // R6 inverted park at pe level
    stop_i = 1'b0; run(16, 0);
    test_i = 2'b01; stop_i = 1'b1; bank_sel_i = 16'h5500; run(24, 0);  // R8
    test_i = 2'b11; run(12, 1);         // R9
    test_i = 2'b10; stop_i = 1'b0; pe_i = 1'b1; ref_i = 1'b1;
    @(negedge clk); @(negedge clk);
    check_eq("R1", clk_o, 8'hFF);       // code 10 read as MID -> bypass
    test_i = 2'b00; bank_sel_i = 16'h0F55; run(12, 0);
    rises = 0;
    for (int i = 0; i < 32; i++) begin
      logic prev;
      prev = clk_o[4];
      @(negedge clk);
      if (!prev && clk_o[4]) rises++;
    end
    checks++;
    if (rises != 4) begin
      errors++;
      $display("FAIL R3 divide-by-4 rising edges actual %0d expected 4", rises);
    end
    for (int seg = 0; seg < 400; seg++) begin
      int r;
      r = $urandom_range(0, 9);
      test_i = (r < 6) ? 2'b00 : rnd_code();
      stop_i = 1'($urandom);
      pe_i   = 1'($urandom);
      for (int k = 0; k < 8; k++) bank_sel_i[2*k +: 2] = ($urandom_range(0, 2) == 0) ?
                                   rnd_code() : bank_sel_i[2*k +: 2];
      if ($urandom_range(0, 3) == 0) begin
        rst_ni = 1'b0; #1;
        check_eq("R10", clk_o, 8'h00);
        @(negedge clk); rst_ni = 1'b1;
      end
      run($urandom_range(1, 30), 1);
    end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule